// File: doc/BRIEF.md
# Binary64 to Integer Converter

This block turns an IEEE-754 double-precision operand into a 64-bit two's-complement integer in one registered stage. Each cycle it takes an operand, a two-bit rounding selector and a flag-report enable. One clock later it presents the integer together with three exception flags: invalid, overflow and inexact.

Magnitudes too large for the result do not saturate. The converter keeps the low 64 bits of the aligned significand, so the same operation also yields the unsigned conversion of values up to 2^64. Rounding follows the selected mode and uses every fraction bit that falls below the binary point. Negative inputs are negated after rounding. Trap delivery and register access belong to the surrounding pipeline.

Top module: `f64_to_i64_cvt`

## Requirements
- R1: A normal operand whose biased exponent e lies in 1075..1137 gives exactly (2^52 + fraction) shifted left by e-1075 (low 64 bits), then negated if bit 63 is set. The exponent is bits 62:52 and the fraction is bits 51:0.
- R2: A normal operand with biased exponent 1138 or more gives a result of 0 and raises no flag.
- R3: In the left-shift range, overflow (exc_overflow) is raised when significand bits are pushed above bit 63, and only when flag_en is 1.
- R4: In chopped mode (rnd_mode 00), an operand with biased exponent below 1075 gives its integer part, truncated toward zero.
- R5: A denormal operand (exponent 0, fraction nonzero), or a normal operand with biased exponent 1012 or less, has integer part 0 and counts as having a nonzero discarded part.
- R6: Round-to-nearest-even (rnd_mode 10) rounds the magnitude up when the discarded part exceeds one half. On an exact half it rounds up only if the integer part is odd.
- R7: Toward plus infinity (rnd_mode 11) adds 1 to the magnitude of positive operands, and toward minus infinity (rnd_mode 01) adds 1 to the magnitude of negative operands, whenever the discarded part is nonzero.
- R8: exc_inexact is 1 exactly when the discarded part is nonzero and flag_en is 1. With flag_en at 0, neither exc_inexact nor exc_overflow is ever raised.
- R9: Exponent all ones with a nonzero fraction (NaN) raises exc_invalid whatever flag_en is, and gives result 0.
- R10: Exponent all ones with a zero fraction (infinity) gives result 0 and raises exc_overflow only when flag_en is 1.
- R11: Plus or minus zero gives result 0 with no flag.
- R12: A negative operand's result is the two's complement of the rounded magnitude, wrapping mod 2^64 with no saturation.
- R13: Result and flags appear on the clock edge after the operand is presented. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_bits | input | 64 | Binary64 operand |
| rnd_mode | input | 2 | 00 chopped, 01 toward minus infinity, 10 nearest even, 11 toward plus infinity |
| flag_en | input | 1 | Enables overflow and inexact reporting |
| int_out | output | 64 | Converted integer, registered |
| exc_invalid | output | 1 | NaN operand |
| exc_overflow | output | 1 | Infinity or lost high bits, when enabled |
| exc_inexact | output | 1 | Nonzero discarded fraction, when enabled |

## Verification
Directed operands sit on the exponent edges 1012/1013 (sticky versus real right shift), 1023 (unit magnitude), 1075 (shift zero), 1137/1138 (last wrapping shift versus zero). Exact halves such as 1.5, 2.5 and -2.5 go through every rounding mode, which separates a tie-to-even error from a plain round-half-up. Specials are applied with flag_en both on and off to show which flags depend on reporting and which do not. Random operands concentrated around the alignment boundaries, some with fractions forced to exact halves, are compared every cycle against a bench model built on plain shifts and a shift-back overflow test.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    RM_CHOP = 2'b00,
    RM_DOWN = 2'b01,
    RM_NEAR = 2'b10,
    RM_UP   = 2'b11
  } rm_e;

  // Decide the +1 increment to the magnitude, given that the discarded
  // part is known to be nonzero. half = top discarded bit, below = any lower.
  function automatic logic round_incr(input rm_e rm, input logic sign,
                                      input logic lsb, input logic half,
                                      input logic below);
    logic inc;
    case (rm)
      RM_NEAR: inc = half & (below | lsb);
      RM_UP:   inc = ~sign;
      RM_DOWN: inc = sign;
      default: inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/cvt_unpack.sv
module cvt_unpack #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [EXP_W-1:0]  expo,
  output logic [SIG_W-1:0]  sig,
  output logic              is_zero,
  output logic              is_denorm,
  output logic              is_norm,
  output logic              is_inf,
  output logic              is_nan
);
  logic [FRAC_W-1:0] frac;
  logic exp_min, exp_max, frac_nz;

  assign sign    = word[WORD_W-1];
  assign expo    = word[WORD_W-2:FRAC_W];
  assign frac    = word[FRAC_W-1:0];
  assign exp_min = (expo == '0);
  assign exp_max = (expo == '1);
  assign frac_nz = |frac;

  assign sig       = {~exp_min, frac};
  assign is_zero   = exp_min & ~frac_nz;
  assign is_denorm = exp_min & frac_nz;
  assign is_norm   = ~exp_min & ~exp_max;
  assign is_inf    = exp_max & ~frac_nz;
  assign is_nan    = exp_max & frac_nz;
endmodule

// File: rtl/cvt_align.sv
module cvt_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int LW     = SIG_W + INT_W,
  localparam int SH_W   = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int ALIGN0 = BIAS + FRAC_W
) (
  input  logic [EXP_W-1:0] expo,
  input  logic [SIG_W-1:0] sig,
  input  logic             is_norm,
  input  logic             is_denorm,
  output logic [INT_W-1:0] mag,
  output logic [INT_W-1:0] rword,
  output logic             lost_hi
);
  localparam logic signed [SH_W-1:0] LIM = SH_W'(INT_W - 1);
  localparam logic signed [SH_W-1:0] OFS = SH_W'(ALIGN0);

  logic signed [SH_W-1:0] sh, rs;
  logic [LW-1:0] lwide, rwide;

  assign sh    = $signed({2'b00, expo}) - OFS;
  assign rs    = -sh;
  assign lwide = {{INT_W{1'b0}}, sig} << sh;
  assign rwide = {sig, {INT_W{1'b0}}} >> rs;

  always_comb begin
    mag     = '0;
    rword   = '0;
    lost_hi = 1'b0;
    if (is_denorm) begin
      rword = INT_W'(1);
    end else if (is_norm) begin
      if (sh >= 0) begin
        if (sh < LIM) begin
          mag     = lwide[INT_W-1:0];
          lost_hi = |lwide[LW-1:INT_W];
        end
      end else if (rs < LIM) begin
        mag   = {{(INT_W-SIG_W){1'b0}}, rwide[LW-1:INT_W]};
        rword = rwide[INT_W-1:0];
      end else begin
        rword = INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round #(
  parameter int INT_W = 64
) (
  input  logic [1:0]       rm,
  input  logic             sign,
  input  logic             report,
  input  logic [INT_W-1:0] mag,
  input  logic [INT_W-1:0] rword,
  output logic             rword_nz,
  output logic             inexact,
  output logic [INT_W-1:0] res
);
  import cvt_pkg::*;
  logic inc;
  logic [INT_W-1:0] rounded;

  assign rword_nz = |rword;
  assign inc = rword_nz & round_incr(rm_e'(rm), sign, mag[0], rword[INT_W-1],
                                     |rword[INT_W-2:0]);
  assign rounded = mag + INT_W'(inc);
  assign res     = sign ? (~rounded + INT_W'(1)) : rounded;
  assign inexact = report & rword_nz;
endmodule

// File: rtl/f64_to_i64_cvt.sv
module f64_to_i64_cvt #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] op_bits,
  input  logic [1:0]        rnd_mode,
  input  logic              flag_en,
  output logic [INT_W-1:0]  int_out,
  output logic              exc_invalid,
  output logic              exc_overflow,
  output logic              exc_inexact
);
  logic             sign, is_zero, is_denorm, is_norm, is_inf, is_nan;
  logic [EXP_W-1:0] expo;
  logic [SIG_W-1:0] sig;
  logic [INT_W-1:0] mag, rword, res;
  logic             ev_lost, ev_rword_nz, inx_c, ovf_c;

  cvt_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
    .word(op_bits), .sign(sign), .expo(expo), .sig(sig),
    .is_zero(is_zero), .is_denorm(is_denorm), .is_norm(is_norm),
    .is_inf(is_inf), .is_nan(is_nan)
  );

  cvt_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .expo(expo), .sig(sig), .is_norm(is_norm), .is_denorm(is_denorm),
    .mag(mag), .rword(rword), .lost_hi(ev_lost)
  );

  cvt_round #(.INT_W(INT_W)) u_round (
    .rm(rnd_mode), .sign(sign), .report(flag_en), .mag(mag), .rword(rword),
    .rword_nz(ev_rword_nz), .inexact(inx_c), .res(res)
  );

  assign ovf_c = flag_en & (is_inf | ev_lost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out      <= '0;
      exc_invalid  <= 1'b0;
      exc_overflow <= 1'b0;
      exc_inexact  <= 1'b0;
    end else begin
      int_out      <= res;
      exc_invalid  <= is_nan;
      exc_overflow <= ovf_c;
      exc_inexact  <= inx_c;
    end
  end

  logic unused_zero;
  assign unused_zero = is_zero;
endmodule

// File: rtl/cvt_chk.sv
module cvt_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] op_bits,
  input logic              flag_en,
  input logic [INT_W-1:0]  int_out,
  input logic              exc_invalid,
  input logic              exc_overflow,
  input logic              exc_inexact,
  input logic              ev_lost,
  input logic              ev_rword_nz
);
  logic op_exp_max, op_frac_nz;
  assign op_exp_max = (op_bits[WORD_W-2:FRAC_W] == '1);
  assign op_frac_nz = |op_bits[FRAC_W-1:0];

  p_nan_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_exp_max && op_frac_nz) |=> (exc_invalid && int_out == '0));

  p_inf_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_exp_max && !op_frac_nz && flag_en) |=> (exc_overflow && int_out == '0));

  p_no_report_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> (!exc_overflow && !exc_inexact));

  p_inexact_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rword_nz && flag_en) |=> exc_inexact);

  p_lost_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lost && flag_en) |=> exc_overflow);

  p_zero_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_bits[WORD_W-2:0] == '0) |=>
      (int_out == '0 && !exc_invalid && !exc_overflow && !exc_inexact));
endmodule

bind f64_to_i64_cvt cvt_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .flag_en(flag_en),
  .int_out(int_out), .exc_invalid(exc_invalid), .exc_overflow(exc_overflow),
  .exc_inexact(exc_inexact), .ev_lost(ev_lost), .ev_rword_nz(ev_rword_nz)
);

// File: tb/sim_f64_to_i64_cvt.sv
module sim_f64_to_i64_cvt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_bits = '0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        flag_en = 1'b0;
  logic [63:0] int_out;
  logic        exc_invalid, exc_overflow, exc_inexact;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [63:0] q_res[$];
  logic [2:0]  q_fl[$];
  string       q_tag[$];
  logic [63:0] q_op[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  f64_to_i64_cvt u0 (
    .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .rnd_mode(rnd_mode),
    .flag_en(flag_en), .int_out(int_out), .exc_invalid(exc_invalid),
    .exc_overflow(exc_overflow), .exc_inexact(exc_inexact)
  );

  // Behavioural model: flags packed as {invalid, overflow, inexact}.
  function automatic void model(input logic [63:0] a, input logic [1:0] rm,
                                input logic rep, output logic [63:0] r,
                                output logic [2:0] fl);
    logic        s;
    int          e, sh, rsh;
    logic [63:0] m, mag, rw;
    s = a[63];
    e = int'(a[62:52]);
    m = {11'd0, 1'b1, a[51:0]};
    mag = 0; rw = 0; fl = 3'b000;
    if (e == 0) begin
      if (a[51:0] != 0) rw = 64'd1;
    end else if (e == 2047) begin
      if (a[51:0] != 0) fl[2] = 1'b1;
      else fl[1] = rep;
    end else begin
      sh = e - 1075;
      if (sh >= 0) begin
        if (sh < 63) begin
          mag = m << sh;
          if (rep && ((mag >> sh) != m)) fl[1] = 1'b1;
        end
      end else begin
        rsh = -sh;
        if (rsh < 63) begin
          mag = m >> rsh;
          rw  = m << (64 - rsh);
        end else begin
          rw = 64'd1;
        end
      end
    end
    if (rw != 0) begin
      fl[0] = rep;
      case (rm)
        2'b10: begin
          if (rw == 64'h8000_0000_0000_0000) mag = mag + {63'd0, mag[0]};
          else if (rw > 64'h8000_0000_0000_0000) mag = mag + 1;
        end
        2'b11: mag = mag + {63'd0, ~s};
        2'b01: mag = mag + {63'd0, s};
        default: ;
      endcase
    end
    r = s ? (64'd0 - mag) : mag;
  endfunction

  function automatic string classify(input logic [63:0] a, input logic [1:0] rm);
    int e;
    e = int'(a[62:52]);
    if (e == 2047) return (a[51:0] != 0) ? "R9" : "R10";
    if (e == 0) return (a[51:0] != 0) ? "R5" : "R11";
    if (e >= 1138) return "R2";
    if (e >= 1075) return "R1";
    if (e <= 1012) return "R5";
    case (rm)
      2'b10: return "R6";
      2'b00: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic compare_head();
    logic [63:0] er; logic [2:0] ef; string t; logic [63:0] o;
    logic [2:0] gf;
    if (q_res.size() == 0) return;
    er = q_res.pop_front(); ef = q_fl.pop_front();
    t = q_tag.pop_front(); o = q_op.pop_front();
    gf = {exc_invalid, exc_overflow, exc_inexact};
    n_checks++;
    if (int_out !== er || gf !== ef) begin
      n_errors++;
      $display("FAIL %s R13 op=%h got res=%h fl=%b expected res=%h fl=%b",
               t, o, int_out, gf, er, ef);
    end
  endtask

  // Each negedge: check what the previous operand produced, then drive a new one.
  task automatic push(input logic [63:0] a, input logic [1:0] rm,
                      input logic rep, input string tag);
    logic [63:0] r; logic [2:0] fl;
    @(negedge clk);
    compare_head();
    model(a, rm, rep, r, fl);
    q_res.push_back(r); q_fl.push_back(fl);
    q_tag.push_back(tag); q_op.push_back(a);
    op_bits = a; rnd_mode = rm; flag_en = rep;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog R13 run did not complete");
    finish_run();
  end

  initial begin
    op_bits = mk(1'b0, 1075, 52'h1234);
    flag_en = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (int_out !== 64'd0 || {exc_invalid, exc_overflow, exc_inexact} !== 3'b000) begin
      n_errors++;
      $display("FAIL R13 reset got res=%h fl=%b expected res=0 fl=000",
               int_out, {exc_invalid, exc_overflow, exc_inexact});
    end
    rst_n = 1'b1;

    // R1 exponent 1023 and 1075 boundaries
    push(mk(1'b0, 1023, 52'h0), 2'b00, 1'b1, "R1");
    push(mk(1'b0, 1075, 52'hABCDE), 2'b10, 1'b1, "R1");
    push(mk(1'b1, 1080, 52'h12345), 2'b00, 1'b1, "R1 R12");
    // R3 overflow at shift 62, with and without reporting
    push(mk(1'b0, 1137, 52'h3), 2'b00, 1'b1, "R3");
    push(mk(1'b0, 1137, 52'h3), 2'b00, 1'b0, "R3");
    push(mk(1'b0, 1127, 52'h0), 2'b00, 1'b1, "R3 R12");
    // R2 exponent 1138 and far above
    push(mk(1'b0, 1138, 52'hF), 2'b11, 1'b1, "R2");
    push(mk(1'b1, 2000, 52'h1), 2'b01, 1'b1, "R2");
    // R4 truncation
    push(mk(1'b0, 1024, 52'hC000000000000), 2'b00, 1'b1, "R4");
    push(mk(1'b1, 1024, 52'hC000000000000), 2'b00, 1'b1, "R4 R12");
    // R6 ties: 1.5, 2.5, -2.5, and just above half
    push(mk(1'b0, 1023, 52'h8000000000000), 2'b10, 1'b1, "R6");
    push(mk(1'b0, 1024, 52'h4000000000000), 2'b10, 1'b1, "R6");
    push(mk(1'b1, 1024, 52'h4000000000000), 2'b10, 1'b1, "R6 R12");
    push(mk(1'b0, 1024, 52'h4000000000001), 2'b10, 1'b1, "R6");
    // R7 directed modes on +-2.5
    for (int m = 0; m < 4; m++) begin
      push(mk(1'b0, 1024, 52'h4000000000000), 2'(m), 1'b1, "R7");
      push(mk(1'b1, 1024, 52'h4000000000000), 2'(m), 1'b1, "R7 R12");
    end
    // R5 sticky cases: 1012 vs 1013, denormals
    push(mk(1'b0, 1012, 52'hFFFFFFFFFFFFF), 2'b11, 1'b1, "R5");
    push(mk(1'b1, 1012, 52'h0), 2'b01, 1'b1, "R5");
    push(mk(1'b0, 1013, 52'h0), 2'b10, 1'b1, "R5");
    push(mk(1'b0, 0, 52'h1), 2'b11, 1'b1, "R5");
    push(mk(1'b1, 0, 52'h1), 2'b01, 1'b1, "R5");
    push(mk(1'b1, 0, 52'h1), 2'b10, 1'b1, "R5");
    // R8 inexact gating
    push(mk(1'b0, 1020, 52'h1), 2'b11, 1'b0, "R8");
    push(mk(1'b0, 1030, 52'h0), 2'b11, 1'b1, "R8");
    // R9 NaN regardless of flag_en
    push(mk(1'b0, 2047, 52'h1), 2'b10, 1'b0, "R9");
    push(mk(1'b1, 2047, 52'h8000000000000), 2'b00, 1'b1, "R9");
    // R10 infinity
    push(mk(1'b0, 2047, 52'h0), 2'b00, 1'b1, "R10");
    push(mk(1'b1, 2047, 52'h0), 2'b00, 1'b0, "R10");
    // R11 zeros
    push(mk(1'b0, 0, 52'h0), 2'b11, 1'b1, "R11");
    push(mk(1'b1, 0, 52'h0), 2'b01, 1'b1, "R11");

    // Random operands around the alignment edges, some forced to exact halves
    for (int i = 0; i < 4000; i++) begin
      logic [51:0] f; int e; logic s; int k; logic [1:0] rm; logic rep;
      f  = {$urandom(), $urandom()};
      e  = 1005 + int'($urandom_range(0, 140));
      s  = 1'($urandom());
      rm = 2'($urandom());
      rep = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 19) == 0) e = ($urandom_range(0, 1) != 0) ? 2047 : 0;
      k = 1075 - e;
      if ((i % 4) == 0 && k >= 1 && k <= 52) begin
        f = f & ~((52'd1 << k) - 52'd1);
        f = f | (52'd1 << (k - 1));
      end
      push(mk(s, e, f), rm, rep, classify(mk(s, e, f), rm));
    end
    @(negedge clk);
    compare_head();
    finish_run();
  end
endmodule